// File: doc/BRIEF.md
# Exception entry sequencer

This block carries out the fixed hardware sequence a small 32-bit CPU core runs when it takes an exception. The core offers one request on a valid/ready handshake. The request carries its kind: trap/break, non-maskable interrupt, bus fault or external interrupt. It also carries the three candidate vectors, the current PC, the delay-slot amount and the current special-register values. The sequencer latches the request. It then produces, in one cycle, write strobes and data for the return-address registers, the status register, the exception-status register and the banked stack pointers.

After the register updates, it issues a single word read for the handler address on a request valid/ready channel. It waits for the response. It loads the returned word into the PC and then signals completion, so that the core clears its pending exception. While a sequence is in flight, `req_ready` is low. A new request is held off until the block returns to idle. The inputs of a request are sampled only in the cycle it is accepted. The read request holds `rd_addr` steady until `rd_ready` is seen. The read response needs no ready, because the block always accepts it while waiting. If the response reports a bus error, the block does not raise a nested exception. It flags an error output, does not load the PC, and still completes.

Top module: `exc_entry_seq`

## Requirements
- R1: The vector is selected by kind (0 trap: `trap_vec`, 1 NMI: constant 0, 2 bus fault: `busf_vec`, 3 interrupt: `irq_vec`). `exs_out` equals the low 8 bits of that vector placed at bits [15:8], with every other bit zero, and is written with `exs_we`.
- R2: For kinds 0, 2 and 3, `erp_we` writes `pc_in - dslot_in`. For the NMI, `nrp_we` writes the unmodified `pc_in` instead. The two strobes are never high together.
- R3: For the NMI, the mode bit M (bit 9 of `ccs_in`) is cleared before the status shift. For the other kinds it is kept.
- R4: `ccs_out` keeps bits [31:30] of the input status, puts old bits [19:0] at [29:10], and zeroes bits [9:0]. This clears the user bit U (bit 8).
- R5: When U (bit 8 of `ccs_in`) is set, `usp_we` writes `sp_in` and `sp_we` writes `ksp_in`. When U is clear, neither strobe fires.
- R6: The handler read is issued at address `ebp_in + 4*vector`. `rd_valid` stays high and `rd_addr` stays stable until `rd_ready` is seen.
- R7: The cycle after an error-free read response, `pc_we` is high and `pc_out` equals the response data.
- R8: `req_ready` is high only when the block is idle. `busy` is high from the cycle after acceptance up to and including the done cycle. Inputs presented while busy do not alter the sequence in progress.
- R9: All register strobes and `dslot_clr` fire together in one cycle after acceptance. Each sequence ends with exactly one `done` pulse, after which the block is idle in the next cycle.
- R10: A read response with `rd_rsp_err` set suppresses `pc_we` and raises `fetch_err` together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request offered |
| req_ready | output | 1 | Sequencer can take a request (idle) |
| req_kind | input | 2 | 0 trap, 1 NMI, 2 bus fault, 3 interrupt |
| trap_vec | input | VEC_W | Trap/break vector |
| busf_vec | input | VEC_W | Bus-fault vector |
| irq_vec | input | VEC_W | Vector from interrupt controller |
| pc_in | input | XLEN | Current PC |
| dslot_in | input | DS_W | Delay-slot amount (0 when not in a slot) |
| ccs_in | input | XLEN | Current status register |
| sp_in | input | XLEN | Current stack pointer |
| ksp_in | input | XLEN | Kernel stack pointer |
| ebp_in | input | XLEN | Exception vector table base |
| erp_we | output | 1 | Exception return register write |
| erp_out | output | XLEN | Exception return address |
| nrp_we | output | 1 | NMI return register write |
| nrp_out | output | XLEN | NMI return address |
| ccs_we | output | 1 | Status register write |
| ccs_out | output | XLEN | Shifted status value |
| exs_we | output | 1 | Exception-status write |
| exs_out | output | XLEN | Exception-status value |
| usp_we | output | 1 | User stack pointer write |
| usp_out | output | XLEN | Saved user stack pointer |
| sp_we | output | 1 | Stack pointer write |
| sp_out | output | XLEN | New stack pointer |
| dslot_clr | output | 1 | Clear delay-slot indicator |
| rd_valid | output | 1 | Handler read request valid |
| rd_ready | input | 1 | Handler read request accepted |
| rd_addr | output | XLEN | Handler read address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | XLEN | Read response word |
| rd_rsp_err | input | 1 | Read response bus error |
| pc_we | output | 1 | PC write |
| pc_out | output | XLEN | Handler address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, clear pending exception |
| fetch_err | output | 1 | Handler fetch bus error |

## Verification
The bench sweeps every exception kind against user and kernel status and against every delay-slot amount, with read-channel stalls of varying length on both the request and the response. An NMI that used the ordinary return register, or that corrected its address by the slot amount, would show a wrong `nrp_out` or a stray `erp_we`. A status shift that was off by a bit or left U set would show in `ccs_out`, and a vector table index that was not scaled by four would show in `rd_addr`. During each sequence the bench changes every request input while keeping `req_valid` high. A sequencer that sampled its inputs late, or accepted a second request, would then write the wrong values or fail to go idle. A final run with an erroring response checks that the PC stays untouched and that the error flag comes with completion.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    EXC_TRAP = 2'd0,
    EXC_NMI  = 2'd1,
    EXC_BUSF = 2'd2,
    EXC_IRQ  = 2'd3
  } exc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_FETCH,
    ST_WAIT,
    ST_LOAD,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [1:0]       kind,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] busf_vec,
  input  logic [VEC_W-1:0] irq_vec,
  output logic [VEC_W-1:0] vec,
  output logic             is_nmi
);
  always_comb begin
    is_nmi = 1'b0;
    unique case (exc_kind_e'(kind))
      EXC_TRAP: vec = trap_vec;
      EXC_NMI: begin
        vec    = '0;
        is_nmi = 1'b1;
      end
      EXC_BUSF: vec = busf_vec;
      default:  vec = irq_vec;
    endcase
  end
endmodule

// File: rtl/exc_status_xform.sv
module exc_status_xform #(
  parameter int XLEN  = 32,
  parameter int LVL_W = 10,
  parameter int M_BIT = 9,
  parameter int U_BIT = 8
) (
  input  logic [XLEN-1:0] ccs_in,
  input  logic            clear_m,
  output logic [XLEN-1:0] ccs_new,
  output logic            user_mode
);
  localparam int KEEP_W = 2;
  localparam int MOVE_W = XLEN - KEEP_W - LVL_W;

  logic [XLEN-1:0] masked;
  logic            unused_dropped;

  always_comb begin
    masked = ccs_in;
    if (clear_m) masked[M_BIT] = 1'b0;
  end

  // Keep the top field, push the low levels up by one, empty the bottom level.
  assign ccs_new        = {masked[XLEN-1 -: KEEP_W], masked[MOVE_W-1:0], {LVL_W{1'b0}}};
  assign user_mode      = ccs_in[U_BIT];
  assign unused_dropped = ^masked[XLEN-KEEP_W-1:MOVE_W];
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
  parameter int XLEN = 32,
  parameter int DS_W = 2
) (
  input  logic [XLEN-1:0] pc,
  input  logic [DS_W-1:0] dslot,
  output logic [XLEN-1:0] erp_val,
  output logic [XLEN-1:0] nrp_val
);
  // Step back over the branch so that it re-executes after return.
  assign erp_val = pc - XLEN'(dslot);
  assign nrp_val = pc;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8,
  parameter int DS_W  = 2,
  parameter int LVL_W = 10,
  parameter int M_BIT = 9,
  parameter int U_BIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] busf_vec,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [DS_W-1:0]  dslot_in,
  input  logic [XLEN-1:0]  ccs_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  ksp_in,
  input  logic [XLEN-1:0]  ebp_in,
  output logic             erp_we,
  output logic [XLEN-1:0]  erp_out,
  output logic             nrp_we,
  output logic [XLEN-1:0]  nrp_out,
  output logic             ccs_we,
  output logic [XLEN-1:0]  ccs_out,
  output logic             exs_we,
  output logic [XLEN-1:0]  exs_out,
  output logic             usp_we,
  output logic [XLEN-1:0]  usp_out,
  output logic             sp_we,
  output logic [XLEN-1:0]  sp_out,
  output logic             dslot_clr,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [XLEN-1:0]  rd_addr,
  input  logic             rd_rsp_valid,
  input  logic [XLEN-1:0]  rd_rsp_data,
  input  logic             rd_rsp_err,
  output logic             pc_we,
  output logic [XLEN-1:0]  pc_out,
  output logic             busy,
  output logic             done,
  output logic             fetch_err
);
  localparam int IDX_W = 8;
  localparam int IDX_LO = 8;

  seq_state_e       state_q, state_d;
  logic             accept;
  logic [VEC_W-1:0] vec_sel, vec_q;
  logic             nmi_sel, nmi_q;
  logic [XLEN-1:0]  pc_q, ccs_q, sp_q, ksp_q, ebp_q, hdl_q;
  logic [DS_W-1:0]  ds_q;
  logic             err_q;
  logic             in_save;
  logic             user_q;
  logic [XLEN-1:0]  erp_val, nrp_val, ccs_new;
  logic [IDX_W-1:0] idx;

  assign accept = req_valid && req_ready;

  exc_vec_sel #(.VEC_W(VEC_W)) vsel_i (
    .kind     (req_kind),
    .trap_vec (trap_vec),
    .busf_vec (busf_vec),
    .irq_vec  (irq_vec),
    .vec      (vec_sel),
    .is_nmi   (nmi_sel)
  );

  // Request latch: all inputs are taken only in the accept cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      nmi_q <= 1'b0;
      pc_q  <= '0;
      ds_q  <= '0;
      ccs_q <= '0;
      sp_q  <= '0;
      ksp_q <= '0;
      ebp_q <= '0;
    end else if (accept) begin
      vec_q <= vec_sel;
      nmi_q <= nmi_sel;
      pc_q  <= pc_in;
      ds_q  <= dslot_in;
      ccs_q <= ccs_in;
      sp_q  <= sp_in;
      ksp_q <= ksp_in;
      ebp_q <= ebp_in;
    end
  end

  exc_status_xform #(
    .XLEN  (XLEN),
    .LVL_W (LVL_W),
    .M_BIT (M_BIT),
    .U_BIT (U_BIT)
  ) sx_i (
    .ccs_in    (ccs_q),
    .clear_m   (nmi_q),
    .ccs_new   (ccs_new),
    .user_mode (user_q)
  );

  exc_ret_addr #(.XLEN(XLEN), .DS_W(DS_W)) ra_i (
    .pc      (pc_q),
    .dslot   (ds_q),
    .erp_val (erp_val),
    .nrp_val (nrp_val)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_SAVE;
      ST_SAVE:  state_d = ST_FETCH;
      ST_FETCH: if (rd_ready) state_d = ST_WAIT;
      ST_WAIT:  if (rd_rsp_valid) state_d = rd_rsp_err ? ST_DONE : ST_LOAD;
      ST_LOAD:  state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdl_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) err_q <= 1'b0;
      if (state_q == ST_WAIT && rd_rsp_valid) begin
        hdl_q <= rd_rsp_data;
        err_q <= rd_rsp_err;
      end
    end
  end

  assign in_save   = (state_q == ST_SAVE);
  assign idx       = IDX_W'(vec_q);

  assign erp_we    = in_save && !nmi_q;
  assign erp_out   = erp_val;
  assign nrp_we    = in_save && nmi_q;
  assign nrp_out   = nrp_val;
  assign ccs_we    = in_save;
  assign ccs_out   = ccs_new;
  assign exs_we    = in_save;
  assign exs_out   = XLEN'({idx, {IDX_LO{1'b0}}});
  assign usp_we    = in_save && user_q;
  assign usp_out   = sp_q;
  assign sp_we     = in_save && user_q;
  assign sp_out    = ksp_q;
  assign dslot_clr = in_save;

  assign rd_valid  = (state_q == ST_FETCH);
  assign rd_addr   = ebp_q + (XLEN'(vec_q) << 2);

  assign pc_we     = (state_q == ST_LOAD);
  assign pc_out    = hdl_q;
  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign fetch_err = done && err_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN  = 32,
  parameter int LVL_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            erp_we,
  input logic            nrp_we,
  input logic            ccs_we,
  input logic [XLEN-1:0] ccs_out,
  input logic            exs_we,
  input logic            usp_we,
  input logic            sp_we,
  input logic            dslot_clr,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [XLEN-1:0] rd_addr,
  input logic            rd_rsp_valid,
  input logic [XLEN-1:0] rd_rsp_data,
  input logic            rd_rsp_err,
  input logic            pc_we,
  input logic [XLEN-1:0] pc_out,
  input logic            busy,
  input logic            done,
  input logic            fetch_err
);
  AST_RET_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(erp_we && nrp_we)); // R2
  AST_CCS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ccs_we |-> (ccs_out[LVL_W-1:0] == '0)); // R4
  AST_SP_PAIR: assert property (@(posedge clk) disable iff (!rst_n) usp_we == sp_we); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R6
  AST_PC_FROM_RSP: assert property (@(posedge clk) disable iff (!rst_n) pc_we |-> $past(rd_rsp_valid && !rd_rsp_err) && pc_out == $past(rd_rsp_data)); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ready |=> busy && !req_ready); // R8
  AST_SAVE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) ccs_we |-> exs_we && dslot_clr && (erp_we || nrp_we)); // R9
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy && req_ready); // R9
  AST_ERR_NO_PC: assert property (@(posedge clk) disable iff (!rst_n) fetch_err |-> done && !pc_we); // R10
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .LVL_W(LVL_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .erp_we       (erp_we),
  .nrp_we       (nrp_we),
  .ccs_we       (ccs_we),
  .ccs_out      (ccs_out),
  .exs_we       (exs_we),
  .usp_we       (usp_we),
  .sp_we        (sp_we),
  .dslot_clr    (dslot_clr),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_addr      (rd_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_data  (rd_rsp_data),
  .rd_rsp_err   (rd_rsp_err),
  .pc_we        (pc_we),
  .pc_out       (pc_out),
  .busy         (busy),
  .done         (done),
  .fetch_err    (fetch_err)
);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  localparam int XLEN = 32;
  localparam int VW   = 8;
  localparam int DW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [1:0]      req_kind = '0;
  logic [VW-1:0]   trap_vec = '0, busf_vec = '0, irq_vec = '0;
  logic [XLEN-1:0] pc_in = '0, ccs_in = '0, sp_in = '0, ksp_in = '0, ebp_in = '0;
  logic [DW-1:0]   dslot_in = '0;
  logic            erp_we, nrp_we, ccs_we, exs_we, usp_we, sp_we, dslot_clr;
  logic [XLEN-1:0] erp_out, nrp_out, ccs_out, exs_out, usp_out, sp_out;
  logic            rd_valid;
  logic            rd_ready = 1'b0;
  logic [XLEN-1:0] rd_addr;
  logic            rd_rsp_valid = 1'b0;
  logic [XLEN-1:0] rd_rsp_data = '0;
  logic            rd_rsp_err = 1'b0;
  logic            pc_we, busy, done, fetch_err;
  logic [XLEN-1:0] pc_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .trap_vec(trap_vec), .busf_vec(busf_vec), .irq_vec(irq_vec),
    .pc_in(pc_in), .dslot_in(dslot_in), .ccs_in(ccs_in), .sp_in(sp_in),
    .ksp_in(ksp_in), .ebp_in(ebp_in),
    .erp_we(erp_we), .erp_out(erp_out), .nrp_we(nrp_we), .nrp_out(nrp_out),
    .ccs_we(ccs_we), .ccs_out(ccs_out), .exs_we(exs_we), .exs_out(exs_out),
    .usp_we(usp_we), .usp_out(usp_out), .sp_we(sp_we), .sp_out(sp_out),
    .dslot_clr(dslot_clr), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err), .pc_we(pc_we), .pc_out(pc_out), .busy(busy),
    .done(done), .fetch_err(fetch_err)
  );

  function automatic logic [XLEN-1:0] hmem(input logic [XLEN-1:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [1:0] k, input logic [VW-1:0] tv, input logic [VW-1:0] bv,
                         input logic [VW-1:0] iv, input logic [XLEN-1:0] pc, input logic [DW-1:0] ds,
                         input logic [XLEN-1:0] ccs, input logic [XLEN-1:0] sp,
                         input logic [XLEN-1:0] ksp, input logic [XLEN-1:0] ebp,
                         input int rdly, input int sdly, input bit err);
    logic [VW-1:0]   vec;
    logic [XLEN-1:0] c, exp_ccs, exp_addr, exp_pc;
    bit g_erp = 0, g_nrp = 0, g_ccs = 0, g_exs = 0, g_usp = 0, g_sp = 0, g_dsc = 0, g_pc = 0;
    bit g_ferr = 0, rdy_bad = 0, busy_bad = 0, addr_bad = 0, g_addr = 0;
    int n_save = 0;
    logic [XLEN-1:0] v_erp = '0, v_nrp = '0, v_ccs = '0, v_exs = '0, v_usp = '0, v_sp = '0;
    logic [XLEN-1:0] v_pc = '0, v_addr = '0;
    int ph = 0, w = 0;
    bit first = 1;

    vec = (k == 2'd0) ? tv : (k == 2'd1) ? 8'h00 : (k == 2'd2) ? bv : iv;
    c = ccs;
    if (k == 2'd1) c[9] = 1'b0;
    exp_ccs  = {c[31:30], c[19:0], 10'b0};
    exp_addr = ebp + 32'(vec) * 4;
    exp_pc   = hmem(exp_addr);

    @(negedge clk);
    req_kind = k; trap_vec = tv; busf_vec = bv; irq_vec = iv; pc_in = pc; dslot_in = ds;
    ccs_in = ccs; sp_in = sp; ksp_in = ksp; ebp_in = ebp; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (first) begin
        // Scramble every input while busy; valid stays high (back-pressure).
        req_kind = ~k; trap_vec = ~tv; busf_vec = ~bv; irq_vec = ~iv; pc_in = ~pc;
        dslot_in = ~ds; ccs_in = ~ccs; sp_in = ~sp; ksp_in = ~ksp; ebp_in = ~ebp;
        first = 0;
      end
      if (req_ready) rdy_bad = 1;
      if (!busy) busy_bad = 1;
      if (erp_we) begin g_erp = 1; v_erp = erp_out; end
      if (nrp_we) begin g_nrp = 1; v_nrp = nrp_out; end
      if (ccs_we) begin g_ccs = 1; v_ccs = ccs_out; n_save++; end
      if (exs_we) begin g_exs = 1; v_exs = exs_out; end
      if (usp_we) begin g_usp = 1; v_usp = usp_out; end
      if (sp_we)  begin g_sp = 1;  v_sp = sp_out; end
      if (dslot_clr) g_dsc = 1;
      if (pc_we)  begin g_pc = 1;  v_pc = pc_out; end
      if (rd_valid) begin
        if (g_addr && rd_addr != v_addr) addr_bad = 1;
        g_addr = 1; v_addr = rd_addr;
      end
      if (done) begin
        g_ferr = fetch_err;
        req_valid = 1'b0;
        break;
      end
      rd_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_err = 1'b0;
      if (ph == 0 && rd_valid) begin
        if (w >= rdly) begin rd_ready = 1'b1; ph = 1; w = 0; end else w++;
      end else if (ph == 1) begin
        if (w >= sdly) begin
          rd_rsp_valid = 1'b1; rd_rsp_data = hmem(v_addr); rd_rsp_err = err; ph = 2;
        end else w++;
      end
    end

    if (k == 2'd1) begin
      chk(g_nrp && v_nrp == pc && !g_erp, "R2 nmi return", v_nrp, pc);
    end else begin
      chk(g_erp && v_erp == pc - 32'(ds) && !g_nrp, "R2 exception return", v_erp, pc - 32'(ds));
    end
    chk(g_ccs && v_ccs == exp_ccs, (k == 2'd1) ? "R3 R4 status nmi" : "R4 status shift",
        v_ccs, exp_ccs);
    chk(g_exs && v_exs == {16'h0, vec, 8'h00}, "R1 vector idx", v_exs, {16'h0, vec, 8'h00});
    if (ccs[8]) begin
      chk(g_usp && g_sp && v_usp == sp && v_sp == ksp, "R5 stack swap", v_sp, ksp);
    end else begin
      chk(!g_usp && !g_sp, "R5 no swap", {31'b0, g_sp}, 32'h0);
    end
    chk(g_addr && !addr_bad && v_addr == exp_addr, "R6 handler address", v_addr, exp_addr);
    if (err) begin
      chk(!g_pc && g_ferr, "R10 fetch error", {31'b0, g_pc}, 32'h0);
    end else begin
      chk(g_pc && v_pc == exp_pc && !g_ferr, "R7 pc load", v_pc, exp_pc);
    end
    chk(!rdy_bad && !busy_bad, "R8 busy window", {30'b0, rdy_bad, busy_bad}, 32'h0);
    chk(g_dsc && n_save == 1, "R9 save once", 32'(n_save), 32'h1);
    @(negedge clk);
    chk(!busy && req_ready && !done, "R9 idle after done", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && req_ready && !rd_valid && !done, "R8 reset state", {31'b0, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req_ready && !pc_we && !ccs_we, "R8 after reset", {31'b0, busy}, 32'h0);
    for (int k = 0; k < 4; k++) begin
      for (int u = 0; u < 2; u++) begin
        for (int d = 0; d < 4; d++) begin
          logic [XLEN-1:0] cc;
          cc = 32'hC00A5AFF ^ (32'(k) << 12) ^ (32'(d) << 24);
          cc[8] = u[0];
          cc[9] = 1'b1;
          run_seq(2'(k), 8'(8'h11 * (d + 1)), (d == 3) ? 8'hFF : 8'(8'h21 + d),
                  8'(8'hE0 + 4 * k + d), 32'h4000_1000 + 32'(k * 64 + d * 4 + u),
                  2'(d), cc, 32'hBEEF_0000 + 32'(d), 32'h8000_7F00 + 32'(k),
                  32'h0001_0000 * 32'(k + 1), d % 3, (k + d) % 2, 1'b0);
        end
      end
    end
    run_seq(2'd3, 8'h05, 8'h06, 8'h9C, 32'h0000_2222, 2'd2, 32'h0000_0100,
            32'h1234_5678, 32'h8765_4321, 32'h0002_0000, 1, 2, 1'b1);
    run_seq(2'd2, 8'h05, 8'hFF, 8'h9C, 32'h0000_0001, 2'd3, 32'hFFFF_FFFF,
            32'h1111_2222, 32'h3333_4444, 32'hFFFF_FF00, 0, 0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule